// File: doc/BRIEF.md
# Serialized Interrupt Request Slave

This block is the device end of a one-wire serialized interrupt scheme that runs on the bus clock. Several devices and a host share a single open-drain line that a pull-up holds high. The block never touches a pad. It watches the line level as `line_in` and presents a drive request as an enable (`line_oe`) and a value (`line_out`). It carries sixteen active-low interrupt request inputs onto the wire. Each request is placed in its own three-clock slot of a transfer that a start pulse opens.

A transfer begins with a long low pulse on the line. Frames are counted from the first clock on which the line reads high again, and this holds whichever device pulled the line low. Every frame has three clocks: sample, recovery and turn-around. In the sample clock of its slot, the block pulls the line low when the matching request is low. In the recovery clock it drives the line back high. In the turn-around clock it lets go. After the sixteen request frames comes one spare frame, which the block never drives. The block then waits for a short stop pulse and goes idle. In quiet mode the block may also open a transfer itself, with a single low clock, when a request has changed and the line is idle. In continuous mode only the host opens transfers.

Top module: `serirq_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `line_oe` is 0. Reset leaves the block idle with every request treated as last sent inactive (1).
- R2: A transfer opens only when the line has been low for at least 4 consecutive clocks while idle and then reads high. A low of 1 to 3 clocks while idle starts nothing, and the block keeps the line released.
- R3: Call the first high cycle after the start pulse cycle 0. In cycle 3n+2, for n = 0..15, the block drives low (`line_oe`=1, `line_out`=0) if `irq_n[n]` is 0, and leaves the line released if it is 1. Bit n of `irq_n` belongs to frame n.
- R4: The block drives high (`line_oe`=1, `line_out`=1) only in cycle 3n+3, the cycle right after it drove low in cycle 3n+2, and only for that one clock. It never drives in turn-around cycle 3n+4.
- R5: Frame 16 (cycles 50 to 52) is never driven. After it the block waits for a stop pulse: low for 2 or 3 clocks, then high. It then goes idle with the line released.
- R6: In quiet mode (`quiet_mode`=1), when the block is idle, the line is high and a request is pending, the block drives low for exactly one clock. It then releases the line without ever driving it high.
- R7: A request is pending when an `irq_n` bit differs from the level it had when its frame was last sampled. With no pending request, a quiet-mode block that is idle leaves the line released.
- R8: During a transfer the block never opens a new one. A request that changes before its frame's sample cycle goes out in the current transfer. A request whose slot has already passed stays pending, and the block opens a transfer after the stop pulse.
- R9: In continuous mode (`quiet_mode`=0) the block never drives the line while idle. It still places requests in transfers that the host opens.
- R10: A low on the line during a recovery or turn-around cycle of a transfer aborts it. From the next cycle the line is released and the block is idle, and it waits for a new start of at least 4 low clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| quiet_mode | input | 1 | 1 = quiet mode (may start transfers), 0 = continuous mode |
| irq_n | input | 16 | Active-low interrupt requests; bit n is carried in frame n |
| line_in | input | 1 | Level of the shared line |
| line_oe | output | 1 | 1 = drive the shared line with `line_out` |
| line_out | output | 1 | Value to drive when `line_oe` is 1 |

## Verification
The bench checks slot placement against the clock count from the rising edge with several request patterns and start widths. A one-clock offset in the slot position shows up as a low in the wrong frame or a drive during turn-around. Short low pulses while idle must not open a transfer, so a detector that is too eager would drive slots on noise. The tests change a request in the middle of a transfer, both before and after its slot. A block that tracked pending state wrongly would either drop the late request or start a transfer while one is already running. The bench also forces a low during a turn-around cycle, where a block that failed to abort would go on driving later slots, and it checks that a self-started pulse is one clock wide and is never followed by a high drive.

// File: rtl/serirq_pkg.sv
`timescale 1ns/1ps
package serirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAMES = 2'd1,
    ST_STOPW  = 2'd2
  } sirq_state_t;

  typedef enum logic [1:0] {
    PH_SMP = 2'd0,
    PH_REC = 2'd1,
    PH_TA  = 2'd2
  } sirq_phase_t;
endpackage

// File: rtl/serirq_lowrun.sv
`timescale 1ns/1ps
module serirq_lowrun #(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic [RUN_W-1:0] run_len,
  output logic             rose,
  output logic             quiet_line
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;

  // count consecutive low samples, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (line_in) begin
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign run_len    = run_q;
  assign rose       = line_in && (run_q != '0);
  assign quiet_line = line_in && (run_q == '0);
endmodule

// File: rtl/serirq_seq.sv
`timescale 1ns/1ps
module serirq_seq
  import serirq_pkg::*;
#(
  parameter int NUM_FRAMES = 17,
  parameter int START_MIN  = 4,
  parameter int FRM_W      = 5,
  parameter int RUN_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic             rose,
  input  logic [RUN_W-1:0] run_len,
  output sirq_state_t      st,
  output sirq_phase_t      ph,
  output logic [FRM_W-1:0] frm,
  output sirq_state_t      st_n,
  output sirq_phase_t      ph_n,
  output logic [FRM_W-1:0] frm_n
);
  localparam logic [RUN_W-1:0] START_LEN = RUN_W'(START_MIN);
  localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(NUM_FRAMES);

  always_comb begin
    st_n  = st;
    ph_n  = ph;
    frm_n = frm;
    unique case (st)
      ST_IDLE: begin
        if (rose && (run_len >= START_LEN)) begin
          st_n  = ST_FRAMES;
          ph_n  = PH_TA;      // tail of the start frame
          frm_n = '0;
        end
      end
      ST_FRAMES: begin
        if (!line_in && (ph != PH_SMP)) begin
          st_n = ST_IDLE;     // line pulled low where nobody may drive
        end else begin
          unique case (ph)
            PH_SMP: ph_n = PH_REC;
            PH_REC: begin
              ph_n  = PH_TA;
              frm_n = frm + 1'b1;
            end
            default: begin
              if (frm == LAST_FRM) st_n = ST_STOPW;
              else                 ph_n = PH_SMP;
            end
          endcase
        end
      end
      default: begin
        if (rose) st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      ph  <= PH_TA;
      frm <= '0;
    end else begin
      st  <= st_n;
      ph  <= ph_n;
      frm <= frm_n;
    end
  end

  // R2: a transfer opens only after a long enough low run
  a_r2_start_len: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAMES && $past(st) == ST_IDLE) |-> ($past(run_len) >= START_LEN));

  // R10: a low in recovery or turn-around ends the transfer
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAMES && !line_in && ph != PH_SMP) |=> (st == ST_IDLE));
endmodule

// File: rtl/serirq_drive.sv
`timescale 1ns/1ps
module serirq_drive
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int FRM_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               quiet_mode,
  input  logic [NUM_IRQ-1:0] irq_n,
  input  logic               quiet_line,
  input  sirq_state_t        st,
  input  sirq_state_t        st_n,
  input  sirq_phase_t        ph_n,
  input  logic [FRM_W-1:0]   frm_n,
  output logic               line_oe,
  output logic               line_out
);
  localparam int PAD_W = 2 ** FRM_W;

  logic [NUM_IRQ-1:0] sent_q;
  logic [PAD_W-1:0]   irq_pad;
  logic               smp_slot;
  logic               pending;
  logic               low_q;
  logic               oe_d, out_d, low_d;

  assign irq_pad  = {{(PAD_W-NUM_IRQ){1'b1}}, irq_n};
  assign smp_slot = (st_n == ST_FRAMES) && (ph_n == PH_SMP);
  assign pending  = |(irq_n ^ sent_q);

  // remember the level each request had at its last sample slot
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sent
    always_ff @(posedge clk) begin
      if (rst) begin
        sent_q[g] <= 1'b1;
      end else if (smp_slot && (frm_n == FRM_W'(g))) begin
        sent_q[g] <= irq_n[g];
      end
    end
  end

  always_comb begin
    oe_d  = 1'b0;
    out_d = 1'b1;
    low_d = 1'b0;
    if (smp_slot && !irq_pad[frm_n]) begin
      oe_d  = 1'b1;
      out_d = 1'b0;
      low_d = 1'b1;
    end else if ((st_n == ST_FRAMES) && (ph_n == PH_REC) && low_q) begin
      oe_d  = 1'b1;
      out_d = 1'b1;
    end else if ((st == ST_IDLE) && (st_n == ST_IDLE) && quiet_mode &&
                 pending && quiet_line && !line_oe) begin
      oe_d  = 1'b1;
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_oe  <= 1'b0;
      line_out <= 1'b1;
      low_q    <= 1'b0;
    end else begin
      line_oe  <= oe_d;
      line_out <= out_d;
      low_q    <= low_d;
    end
  end

  // R4: a high drive only follows a low drive
  a_r4_high_after_low: assert property (@(posedge clk) disable iff (rst)
    (line_oe && line_out) |-> $past(line_oe && !line_out));

  // R4: the high drive lasts one clock
  a_r4_single_high: assert property (@(posedge clk) disable iff (rst)
    (line_oe && line_out) |=> !line_oe);

  // R6: a self-started pulse is one low clock, then release
  a_r6_start_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && line_oe) |=> !line_oe);

  // R9: idle drive only in quiet mode and only low
  a_r9_idle_drive_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && line_oe) |-> (!line_out && $past(quiet_mode)));
endmodule

// File: rtl/serirq_slave.sv
`timescale 1ns/1ps
module serirq_slave
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ      = 16,
  parameter int EXTRA_FRAMES = 1,
  parameter int START_MIN    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               quiet_mode,
  input  logic [NUM_IRQ-1:0] irq_n,
  input  logic               line_in,
  output logic               line_oe,
  output logic               line_out
);
  localparam int NUM_FRAMES = NUM_IRQ + EXTRA_FRAMES;
  localparam int FRM_W      = $clog2(NUM_FRAMES + 1);
  localparam int RUN_W      = $clog2(START_MIN + 1);

  logic [RUN_W-1:0] run_len;
  logic             rose;
  logic             quiet_line;
  sirq_state_t      st, st_n;
  sirq_phase_t      ph, ph_n;
  logic [FRM_W-1:0] frm, frm_n;

  serirq_lowrun #(.RUN_W(RUN_W)) u_lowrun (
    .clk        (clk),
    .rst        (rst),
    .line_in    (line_in),
    .run_len    (run_len),
    .rose       (rose),
    .quiet_line (quiet_line)
  );

  serirq_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .START_MIN  (START_MIN),
    .FRM_W      (FRM_W),
    .RUN_W      (RUN_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .line_in (line_in),
    .rose    (rose),
    .run_len (run_len),
    .st      (st),
    .ph      (ph),
    .frm     (frm),
    .st_n    (st_n),
    .ph_n    (ph_n),
    .frm_n   (frm_n)
  );

  serirq_drive #(
    .NUM_IRQ (NUM_IRQ),
    .FRM_W   (FRM_W)
  ) u_drive (
    .clk        (clk),
    .rst        (rst),
    .quiet_mode (quiet_mode),
    .irq_n      (irq_n),
    .quiet_line (quiet_line),
    .st         (st),
    .st_n       (st_n),
    .ph_n       (ph_n),
    .frm_n      (frm_n),
    .line_oe    (line_oe),
    .line_out   (line_out)
  );

  // R7 and R8: while busy, drive only inside sample or recovery of a frame
  a_r8_busy_no_start: assert property (@(posedge clk) disable iff (rst)
    (line_oe && st != ST_IDLE) |-> (st == ST_FRAMES && ph != PH_TA));

  // R5: the spare frame and beyond are never driven
  a_r5_spare_free: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAMES && frm >= FRM_W'(NUM_IRQ)) |-> !line_oe);
endmodule

// File: tb/test_serirq_slave.sv
`timescale 1ns/1ps
module test_serirq_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        quiet = 1'b0;
  logic        host_low = 1'b0;
  logic [15:0] irq_n = 16'hFFFF;
  logic        line_oe, line_out;
  wire         line = line_oe ? line_out : ~host_low;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  serirq_slave i_serirq_slave (
    .clk        (clk),
    .rst        (rst),
    .quiet_mode (quiet),
    .irq_n      (irq_n),
    .line_in    (line),
    .line_oe    (line_oe),
    .line_out   (line_out)
  );

  // 00 released, 10 driving low, 11 driving high
  function automatic logic [1:0] obs();
    return line_oe ? {1'b1, line_out} : 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(tag, obs(), 2'b00);
    end
  endtask

  task automatic host_start(input int w);
    repeat (w) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic host_stop(input int w);
    repeat (w) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
  endtask

  // walk the frames; called at the negedge of cycle 0
  task automatic walk(input string ctx, input int chg_pos, input logic [15:0] chg_val,
                      input int abort_pos);
    logic prev_low = 1'b0;
    int   last = (abort_pos > 0) ? abort_pos + 12 : 52;
    for (int p = 0; p <= last; p++) begin
      logic [1:0] exp = 2'b00;
      logic       cur_low = 1'b0;
      string      tag = "R2";
      if (p > 0) @(negedge clk);
      if (abort_pos > 0 && p > abort_pos) begin
        tag = "R10";
      end else if (p >= 2) begin
        int f  = (p - 2) / 3;
        int sp = (p - 2) % 3;
        if (f >= 16) tag = "R5";
        else if (sp == 0) tag = "R3";
        else tag = "R4";
        if (sp == 0 && f < 16 && !irq_n[f]) begin
          exp = 2'b10;
          cur_low = 1'b1;
        end else if (sp == 1 && prev_low) begin
          exp = 2'b11;
        end
      end
      chk({tag, " ", ctx}, obs(), exp);
      prev_low = cur_low;
      if (p == chg_pos) irq_n = chg_val;
      if (abort_pos > 0 && p == abort_pos) host_low = 1'b1;
      if (abort_pos > 0 && p == abort_pos + 1) host_low = 1'b0;
    end
  endtask

  // wait for the block to open a transfer, then extend it as the host would
  task automatic quiet_cycle(input string ctx);
    logic found = 1'b0;
    for (int k = 0; k < 6 && !found; k++) begin
      @(negedge clk);
      if (obs() == 2'b10) found = 1'b1;
    end
    chk({"R6 start ", ctx}, found ? 2'b10 : 2'b00, 2'b10);
    if (found) begin
      host_low = 1'b1;
      @(negedge clk);
      chk({"R6 release ", ctx}, obs(), 2'b00);
      repeat (2) @(negedge clk);
      @(negedge clk);
      host_low = 1'b0;
      walk(ctx, -1, 16'h0, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk("R1 in reset", obs(), 2'b00);
    end
    rst = 1'b0;
    idle_check(2, "R1 after reset");
  endtask

  task automatic t_continuous();
    quiet = 1'b0;
    irq_n = 16'hA5F0;
    idle_check(8, "R9 idle no start");
    host_start(4);
    walk("pattern A5F0", -1, 16'h0, 0);
    host_stop(3);
    idle_check(4, "R5 idle after stop");
    irq_n = 16'h7FFE;
    host_start(6);
    walk("pattern 7FFE", -1, 16'h0, 0);
    host_stop(2);
    idle_check(4, "R5 idle after short stop");
  endtask

  task automatic t_short_low();
    quiet = 1'b0;
    irq_n = 16'h0000;
    host_start(3);
    idle_check(20, "R2 three-clock low ignored");
    host_start(1);
    idle_check(12, "R2 one-clock low ignored");
    irq_n = 16'h7FFE;
    idle_check(2, "R2 settle");
  endtask

  task automatic t_quiet_start();
    quiet = 1'b1;
    idle_check(10, "R7 nothing pending");
    irq_n = 16'h7FDE;
    quiet_cycle("quiet 7FDE");
    host_stop(2);
    idle_check(10, "R7 pending cleared");
  endtask

  task automatic t_mid_transfer();
    quiet = 1'b1;
    host_start(4);
    walk("R8 late change", 10, 16'h7DDC, 0);
    host_stop(2);
    quiet_cycle("R8 leftover request");
    host_stop(2);
    idle_check(8, "R8 idle after leftover");
  endtask

  task automatic t_cont_no_start();
    quiet = 1'b0;
    irq_n = 16'hFFFF;
    idle_check(20, "R9 pending but continuous");
    host_start(5);
    walk("R9 insert release", -1, 16'h0, 0);
    host_stop(3);
    irq_n = 16'h5AA5;
    idle_check(6, "R9 idle");
    host_start(4);
    walk("R9 insert 5AA5", -1, 16'h0, 0);
    host_stop(3);
  endtask

  task automatic t_abort();
    quiet = 1'b0;
    irq_n = 16'h0000;
    host_start(4);
    walk("R10 abort at turn-around", -1, 16'h0, 7);
    host_start(4);
    walk("R10 recovered", -1, 16'h0, 0);
    host_stop(3);
    idle_check(4, "R10 idle");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_continuous();
    t_short_low();
    t_quiet_start();
    t_mid_transfer();
    t_cont_no_start();
    t_abort();
    finish_run();
  end

  initial begin
    #(5 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule